// File: doc/BRIEF.md
# Serial port register file with prioritised interrupt

This block is the byte-wide register file of a classic 16550-style serial controller. A processor reaches it through a simple bus with a 3-bit offset. Through that bus it programs the divisor latch, the interrupt enables, line and modem control and a scratch byte. It reads back receive data, line status, modem status and an interrupt identification code. Bit-level serialisation and baud generation sit outside. Received bytes arrive on a valid/byte input. Transmitted bytes leave on a one-cycle strobe with a byte. A companion modem block supplies the modem status and delta nibbles and takes the modem-control bits.

A receive queue holds incoming bytes. It holds one byte while FIFO mode is off and sixteen while it is on. One level-sensitive interrupt line is raised whenever a prioritised reason is pending. The transmitter is modelled as always ready. Every data write therefore leaves a "holding register empty" event pending until software sees it in the identification register. In loopback mode, data writes go into the receive queue instead of out of the block.

Top module: `sercom_regfile`

## Requirements
- R1: The reason code in IIR[3:0] (offset 2 read) is chosen by fixed priority. Line status (overrun set and IER[2]) gives 0110. Receive data (queue non-empty and IER[0]) gives 1100. Transmit-empty pending (IER[1]) gives 0010. Modem (any delta bit and IER[3]) gives 0000. Otherwise the code is 0001.
- R2: `irq_o` is high exactly when the reason is not 0001. It follows the state with one cycle of latency.
- R3: A data write (offset 0, LCR[7]=0) sets the transmit-empty pending flag. An IIR read that returns 0010 clears it.
- R4: IER writes keep bits 3..0 only. IER bits 7..4 always read 0.
- R5: When LCR[7]=1, offsets 0 and 1 read and write the divisor low and high bytes, and data and IER are left untouched.
- R6: FCR (offset 2 write) behaves as follows.
  - Changing bit 0 empties the queue. The depth becomes 16 when the bit is set and 1 when it is clear.
  - A write with bit 0 clear stores 0.
  - A write with bit 0 set and bit 1 set empties the queue.
  - Only bits 0, 3, 7 and 6 are stored.
  - IIR[7:6] read 11 while bit 0 is stored set, and 00 otherwise.
- R7: LSR (offset 5) always reads bit 6 and bit 5 as 1. Bit 0 is 1 when the queue is non-empty. Bit 1 is the overrun flag, which is returned and then cleared by the read.
- R8: Data flow depends on loopback.
  - Outside loopback (MCR[4]=0), a data write pulses `tx_stb_o` with the byte, and `rx_vld_i` pushes `rx_byte_i`.
  - In loopback, a data write pushes the byte into the queue, no strobe is produced, and `rx_vld_i` is ignored.
  - A push into a full queue sets the overrun flag and drops the byte.
- R9: After reset the divisor reads 12 (low) and 0 (high), the depth is 1, and all other registers read 0. LSR reads 0x60 and IIR reads 0x01.
- R10: Data reads pop the queue in arrival order. A data read of an empty queue returns 0xFF.
- R11: An MSR read (offset 6) returns {`mdm_status_i`, `mdm_delta_i`} and pulses `mdm_ack_o` one cycle. Writes to offsets 5 and 6 change nothing.
- R12: MCR (offset 4) keeps bits 4..0, reads them back, and drives them on `mdm_ctrl_o`.
- R13: Read data appears on `bus_rdata` in the cycle after the read access. Scratch (offset 7) and LCR (offset 3) read back what was written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_en | input | 1 | Register access this cycle |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 3 | Register offset |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Registered read data |
| rx_vld_i | input | 1 | Received byte valid |
| rx_byte_i | input | 8 | Received byte |
| tx_stb_o | output | 1 | Transmit byte strobe |
| tx_byte_o | output | 8 | Transmit byte |
| mdm_status_i | input | 4 | Modem line levels (MSR high nibble) |
| mdm_delta_i | input | 4 | Modem change flags (MSR low nibble) |
| mdm_ack_o | output | 1 | Pulse: MSR was read, companion clears deltas |
| mdm_ctrl_o | output | 5 | Modem control bits incl. loopback |
| irq_o | output | 1 | Level interrupt |

## Verification
The bench stacks several interrupt sources at once. It then reads IIR repeatedly, checking that each code appears in priority order and that the transmit-empty event disappears after it has been reported. A wrong priority or a missing clear-on-read would show the wrong code or a stuck 0010. The bench fills the queue to exactly its depth in both the 1-byte and the 16-byte modes, pushes one more byte and reads LSR twice. This exposes an off-by-one capacity, a lost overrun flag or a flag that is never cleared. The bench also toggles FIFO mode with data queued and writes FCR with the enable bit left set. A design that misses the reset-on-toggle, or resets on every FCR write, returns stale or lost bytes. Divisor-latch accesses, LSR and MSR writes, and received bytes in loopback are all followed by reads of what they must not touch.

// File: rtl/sercom_pkg.sv
package sercom_pkg;

  localparam logic [2:0] OFS_DATA = 3'd0;
  localparam logic [2:0] OFS_IER  = 3'd1;
  localparam logic [2:0] OFS_IIR  = 3'd2;
  localparam logic [2:0] OFS_LCR  = 3'd3;
  localparam logic [2:0] OFS_MCR  = 3'd4;
  localparam logic [2:0] OFS_LSR  = 3'd5;
  localparam logic [2:0] OFS_MSR  = 3'd6;
  localparam logic [2:0] OFS_SCR  = 3'd7;

  typedef enum logic [3:0] {
    RSN_MODEM = 4'b0000,
    RSN_NONE  = 4'b0001,
    RSN_THRE  = 4'b0010,
    RSN_LINE  = 4'b0110,
    RSN_RXD   = 4'b1100
  } rsn_t;

endpackage

// File: rtl/sercom_rxq.sv
module sercom_rxq #(
  parameter int DEPTH = 16,
  parameter int DW    = 8,
  localparam int PW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          clr,
  input  logic          deep,
  input  logic          push,
  input  logic [DW-1:0] push_data,
  input  logic          pop,
  output logic [DW-1:0] head,
  output logic [CW-1:0] count,
  output logic          empty,
  output logic          ovf
);

  logic [DW-1:0] mem [DEPTH];
  logic [PW-1:0] wp, rp, lim;
  logic [CW-1:0] cap;
  logic          full, take, give;

  function automatic logic [PW-1:0] step(input logic [PW-1:0] p,
                                         input logic [PW-1:0] l);
    return (p == l) ? '0 : p + 1'b1;
  endfunction

  assign lim   = deep ? PW'(DEPTH - 1) : '0;
  assign cap   = deep ? CW'(DEPTH) : CW'(1);
  assign full  = (count == cap);
  assign empty = (count == '0);
  assign take  = push && (!full || pop) && !clr;
  assign ovf   = push && full && !pop && !clr;
  assign give  = pop && !empty && !clr;
  assign head  = mem[rp];

  always_ff @(posedge clk) begin
    if (take) mem[wp] <= push_data;
  end

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      wp    <= '0;
      rp    <= '0;
      count <= '0;
    end else begin
      if (take) wp <= step(wp, lim);
      if (give) rp <= step(rp, lim);
      count <= count + CW'(take) - CW'(give);
    end
  end

endmodule

// File: rtl/sercom_irqsel.sv
module sercom_irqsel
  import sercom_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic [3:0] ier,
  input  logic       overrun,
  input  logic       rx_avail,
  input  logic       thre_pend,
  input  logic       modem_chg,
  output rsn_t       reason,
  output logic       irq
);

  always_comb begin
    if (overrun && ier[2])        reason = RSN_LINE;
    else if (rx_avail && ier[0])  reason = RSN_RXD;
    else if (thre_pend && ier[1]) reason = RSN_THRE;
    else if (modem_chg && ier[3]) reason = RSN_MODEM;
    else                          reason = RSN_NONE;
  end

  always_ff @(posedge clk) begin
    if (rst) irq <= 1'b0;
    else     irq <= (reason != RSN_NONE);
  end

endmodule

// File: rtl/sercom_regfile.sv
module sercom_regfile
  import sercom_pkg::*;
#(
  parameter int DEPTH  = 16,
  parameter int CLK_HZ = 1843200,
  parameter int BAUD   = 9600,
  localparam int CW    = $clog2(DEPTH + 1),
  localparam int DIV   = CLK_HZ / BAUD / 16
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       bus_en,
  input  logic       bus_we,
  input  logic [2:0] bus_addr,
  input  logic [7:0] bus_wdata,
  output logic [7:0] bus_rdata,
  input  logic       rx_vld_i,
  input  logic [7:0] rx_byte_i,
  output logic       tx_stb_o,
  output logic [7:0] tx_byte_o,
  input  logic [3:0] mdm_status_i,
  input  logic [3:0] mdm_delta_i,
  output logic       mdm_ack_o,
  output logic [4:0] mdm_ctrl_o,
  output logic       irq_o
);

  localparam logic [7:0] DLL_RST = 8'(DIV);
  localparam logic [7:0] DLH_RST = 8'(DIV >> 8);

  logic [7:0] dll_q, dlh_q, lcr_q, fcr_q, scr_q;
  logic [3:0] ier_q;
  logic [4:0] mcr_q;
  logic       oe_q, thre_q;

  logic       wr, rd, dlab, loopb, fifo_en;
  logic       wr_thr, rd_rbr, rd_iir, rd_lsr, rd_msr, wr_fcr;
  logic       q_clr, q_push, q_pop, q_empty, q_ovf;
  logic [7:0] q_in, q_head, rd_val;
  logic [CW-1:0] q_count;
  rsn_t       reason;

  assign wr      = bus_en && bus_we;
  assign rd      = bus_en && !bus_we;
  assign dlab    = lcr_q[7];
  assign loopb   = mcr_q[4];
  assign fifo_en = fcr_q[0];

  assign wr_thr = wr && bus_addr == OFS_DATA && !dlab;
  assign rd_rbr = rd && bus_addr == OFS_DATA && !dlab;
  assign rd_iir = rd && bus_addr == OFS_IIR;
  assign rd_lsr = rd && bus_addr == OFS_LSR;
  assign rd_msr = rd && bus_addr == OFS_MSR;
  assign wr_fcr = wr && bus_addr == OFS_IIR;

  // queue empties on a mode change or on an explicit receiver reset
  assign q_clr  = wr_fcr && ((bus_wdata[0] ^ fcr_q[0]) ||
                             (bus_wdata[0] && bus_wdata[1]));
  assign q_push = loopb ? wr_thr : rx_vld_i;
  assign q_in   = loopb ? bus_wdata : rx_byte_i;
  assign q_pop  = rd_rbr;

  sercom_rxq #(.DEPTH(DEPTH), .DW(8)) rxq_i (
    .clk       (clk),
    .rst       (rst),
    .clr       (q_clr),
    .deep      (fifo_en),
    .push      (q_push),
    .push_data (q_in),
    .pop       (q_pop),
    .head      (q_head),
    .count     (q_count),
    .empty     (q_empty),
    .ovf       (q_ovf)
  );

  sercom_irqsel irqsel_i (
    .clk       (clk),
    .rst       (rst),
    .ier       (ier_q),
    .overrun   (oe_q),
    .rx_avail  (!q_empty),
    .thre_pend (thre_q),
    .modem_chg (|mdm_delta_i),
    .reason    (reason),
    .irq       (irq_o)
  );

  // software-writable registers
  always_ff @(posedge clk) begin
    if (rst) begin
      dll_q <= DLL_RST;
      dlh_q <= DLH_RST;
      ier_q <= '0;
      lcr_q <= '0;
      mcr_q <= '0;
      fcr_q <= '0;
      scr_q <= '0;
    end else if (wr) begin
      case (bus_addr)
        OFS_DATA: if (dlab) dll_q <= bus_wdata;
        OFS_IER:  if (dlab) dlh_q <= bus_wdata;
                  else      ier_q <= bus_wdata[3:0];
        OFS_IIR:  fcr_q <= bus_wdata[0] ? (bus_wdata & 8'hC9) : 8'h00;
        OFS_LCR:  lcr_q <= bus_wdata;
        OFS_MCR:  mcr_q <= bus_wdata[4:0];
        OFS_SCR:  scr_q <= bus_wdata;
        default:  ;
      endcase
    end
  end

  // event flags
  always_ff @(posedge clk) begin
    if (rst) begin
      oe_q   <= 1'b0;
      thre_q <= 1'b0;
    end else begin
      if (q_ovf)       oe_q <= 1'b1;
      else if (rd_lsr) oe_q <= 1'b0;
      if (wr_thr)      thre_q <= 1'b1;
      else if (rd_iir && reason == RSN_THRE) thre_q <= 1'b0;
    end
  end

  always_comb begin
    case (bus_addr)
      OFS_DATA: rd_val = dlab ? dll_q : (q_empty ? 8'hFF : q_head);
      OFS_IER:  rd_val = dlab ? dlh_q : {4'b0000, ier_q};
      OFS_IIR:  rd_val = {{2{fifo_en}}, 2'b00, reason};
      OFS_LCR:  rd_val = lcr_q;
      OFS_MCR:  rd_val = {3'b000, mcr_q};
      OFS_LSR:  rd_val = {1'b0, 1'b1, 1'b1, 3'b000, oe_q, !q_empty};
      OFS_MSR:  rd_val = {mdm_status_i, mdm_delta_i};
      default:  rd_val = scr_q;
    endcase
  end

  // registered outputs
  always_ff @(posedge clk) begin
    if (rst) begin
      bus_rdata <= '0;
      tx_stb_o  <= 1'b0;
      tx_byte_o <= '0;
      mdm_ack_o <= 1'b0;
    end else begin
      if (rd) bus_rdata <= rd_val;
      tx_stb_o  <= wr_thr && !loopb;
      if (wr_thr && !loopb) tx_byte_o <= bus_wdata;
      mdm_ack_o <= rd_msr;
    end
  end

  assign mdm_ctrl_o = mcr_q;

endmodule

// File: rtl/sercom_regfile_chk.sv
module sercom_regfile_chk #(
  parameter int DEPTH = 16,
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input logic          clk,
  input logic          rst,
  input logic          bus_en,
  input logic          bus_we,
  input logic [2:0]    bus_addr,
  input logic [7:0]    bus_rdata,
  input logic          irq_o,
  input logic          dlab,
  input logic [3:0]    ier_q,
  input logic [CW-1:0] q_count,
  input logic          fifo_en,
  input logic          oe_q,
  input logic          q_ovf
);

  logic rd;
  assign rd = bus_en && !bus_we;

  // R4
  ier_hi_zero_chk: assert property (@(posedge clk) disable iff (rst)
    (rd && bus_addr == 3'd1 && !dlab) |=> (bus_rdata[7:4] == 4'h0));

  // R7
  lsr_tx_bits_chk: assert property (@(posedge clk) disable iff (rst)
    (rd && bus_addr == 3'd5) |=> (bus_rdata[6:5] == 2'b11));

  // R7
  oe_clear_chk: assert property (@(posedge clk) disable iff (rst)
    (rd && bus_addr == 3'd5 && !q_ovf) |=> !oe_q);

  // R6
  q_bound_chk: assert property (@(posedge clk) disable iff (rst)
    q_count <= (fifo_en ? CW'(DEPTH) : CW'(1)));

  // R2
  rx_irq_chk: assert property (@(posedge clk) disable iff (rst)
    (q_count != '0 && ier_q[0]) |=> irq_o);

  // R6
  iir_fifo_bits_chk: assert property (@(posedge clk) disable iff (rst)
    (rd && bus_addr == 3'd2 && fifo_en) |=> (bus_rdata[7:6] == 2'b11));

endmodule

bind sercom_regfile sercom_regfile_chk #(.DEPTH(DEPTH)) chk_i (
  .clk       (clk),
  .rst       (rst),
  .bus_en    (bus_en),
  .bus_we    (bus_we),
  .bus_addr  (bus_addr),
  .bus_rdata (bus_rdata),
  .irq_o     (irq_o),
  .dlab      (dlab),
  .ier_q     (ier_q),
  .q_count   (q_count),
  .fifo_en   (fifo_en),
  .oe_q      (oe_q),
  .q_ovf     (q_ovf)
);

// File: tb/sercom_regfile_tb_top.sv
`timescale 1ns/1ps
module sercom_regfile_tb_top;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       bus_en = 1'b0, bus_we = 1'b0;
  logic [2:0] bus_addr = '0;
  logic [7:0] bus_wdata = '0;
  logic [7:0] bus_rdata;
  logic       rx_vld_i = 1'b0;
  logic [7:0] rx_byte_i = '0;
  logic       tx_stb_o;
  logic [7:0] tx_byte_o;
  logic [3:0] mdm_status_i = '0, mdm_delta_i = '0;
  logic       mdm_ack_o;
  logic [4:0] mdm_ctrl_o;
  logic       irq_o;

  int n_chk = 0, n_fail = 0;
  logic [7:0] expq[$];
  string      tagq[$];
  bit         done = 1'b0;

  always #10 clk = ~clk;

  sercom_regfile dut_i (
    .clk(clk), .rst(rst), .bus_en(bus_en), .bus_we(bus_we),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .rx_vld_i(rx_vld_i), .rx_byte_i(rx_byte_i),
    .tx_stb_o(tx_stb_o), .tx_byte_o(tx_byte_o),
    .mdm_status_i(mdm_status_i), .mdm_delta_i(mdm_delta_i),
    .mdm_ack_o(mdm_ack_o), .mdm_ctrl_o(mdm_ctrl_o), .irq_o(irq_o)
  );

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %02h expected %02h", tag, act, exp);
    end
  endtask

  // monitor: compares read data one cycle after each read access
  initial begin
    forever begin
      @(negedge clk);
      #1;
      while (expq.size() > 0) chk(tagq.pop_front(), bus_rdata, expq.pop_front());
    end
  end

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    bus_en = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    @(posedge clk); @(negedge clk);
    bus_en = 1'b0; bus_we = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, input logic [7:0] exp, input string tag);
    bus_en = 1'b1; bus_we = 1'b0; bus_addr = a;
    @(posedge clk); @(negedge clk);
    bus_en = 1'b0;
    expq.push_back(exp);
    tagq.push_back(tag);
  endtask

  task automatic rxp(input logic [7:0] b);
    rx_vld_i = 1'b1; rx_byte_i = b;
    @(posedge clk); @(negedge clk);
    rx_vld_i = 1'b0;
  endtask

  task automatic idle();
    @(posedge clk); @(negedge clk);
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    #(200000 * 20);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_run();
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R9 reset state
    chk("R9 irq", {7'b0, irq_o}, 8'h00);
    chk("R9 mdm_ctrl", {3'b0, mdm_ctrl_o}, 8'h00);
    rd(3, 8'h00, "R9 LCR");
    rd(1, 8'h00, "R9 IER");
    rd(5, 8'h60, "R9 LSR");
    rd(2, 8'h01, "R9 IIR");
    rd(4, 8'h00, "R9 MCR");
    rd(7, 8'h00, "R9 SCR");
    rd(0, 8'hFF, "R10 empty read");
    // R5 divisor latch
    wr(3, 8'h80);
    rd(0, 8'd12, "R9 divisor low");
    rd(1, 8'h00, "R9 divisor high");
    wr(0, 8'h34);
    chk("R5 no tx on DLL write", {7'b0, tx_stb_o}, 8'h00);
    wr(1, 8'h56);
    rd(0, 8'h34, "R5 DLL");
    rd(1, 8'h56, "R5 DLH");
    wr(3, 8'h03);
    rd(3, 8'h03, "R13 LCR");
    rd(1, 8'h00, "R5 IER untouched");
    rd(5, 8'h60, "R5 no push");
    // R4
    wr(1, 8'hFF);
    rd(1, 8'h0F, "R4 IER mask");
    rd(2, 8'h01, "R1 none");
    wr(1, 8'h00);
    wr(7, 8'hA5);
    rd(7, 8'hA5, "R13 scratch");
    wr(4, 8'hE3);
    rd(4, 8'h03, "R12 MCR mask");
    chk("R12 mdm_ctrl", {3'b0, mdm_ctrl_o}, 8'h03);
    // depth-1 receive
    wr(1, 8'h01);
    rxp(8'h11);
    idle();
    chk("R2 irq rx", {7'b0, irq_o}, 8'h01);
    rd(5, 8'h61, "R7 data ready");
    rd(2, 8'h0C, "R1 rx reason");
    rxp(8'h22);
    wr(1, 8'h05);
    rd(2, 8'h06, "R1 line over rx");
    rd(5, 8'h63, "R8 overrun depth1");
    rd(5, 8'h61, "R7 overrun cleared");
    rd(2, 8'h0C, "R1 rx after clear");
    rd(0, 8'h11, "R10 first byte kept");
    rd(0, 8'hFF, "R10 empty");
    idle();
    chk("R2 irq low", {7'b0, irq_o}, 8'h00);
    // 16-deep mode
    wr(2, 8'hCB);
    rd(2, 8'hC1, "R6 IIR fifo bits");
    for (int i = 0; i < 16; i++) rxp(8'(i * 3 + 1));
    rd(5, 8'h61, "R6 full no overrun");
    rxp(8'hEE);
    rd(5, 8'h63, "R8 overrun depth16");
    for (int i = 0; i < 16; i++) rd(0, 8'(i * 3 + 1), "R10 order");
    rd(0, 8'hFF, "R10 drained");
    // FCR reset rules
    rxp(8'h01); rxp(8'h02); rxp(8'h03);
    wr(2, 8'hC3);
    rd(5, 8'h60, "R6 receiver reset");
    rxp(8'h04); rxp(8'h05);
    wr(2, 8'h00);
    rd(5, 8'h60, "R6 disable empties");
    rd(2, 8'h01, "R6 IIR bits clear");
    rxp(8'h01); rxp(8'h02);
    rd(5, 8'h63, "R6 depth back to 1");
    rd(0, 8'h01, "R6 depth1 byte");
    wr(2, 8'h01);
    rxp(8'h07);
    wr(2, 8'hC1);
    rd(0, 8'h07, "R6 no reset when enable kept");
    // transmit-empty
    wr(1, 8'h02);
    wr(0, 8'h77);
    chk("R8 tx strobe", {7'b0, tx_stb_o}, 8'h01);
    chk("R8 tx byte", tx_byte_o, 8'h77);
    idle();
    chk("R8 tx strobe one cycle", {7'b0, tx_stb_o}, 8'h00);
    chk("R3 irq thre", {7'b0, irq_o}, 8'h01);
    rd(2, 8'hC2, "R3 thre reason");
    rd(2, 8'hC1, "R3 thre cleared");
    idle();
    chk("R2 irq after thre read", {7'b0, irq_o}, 8'h00);
    // modem
    mdm_status_i = 4'b1010; mdm_delta_i = 4'b0010;
    wr(1, 8'h0A);
    wr(0, 8'h00);
    rd(2, 8'hC2, "R1 thre over modem");
    rd(2, 8'hC0, "R1 modem reason");
    chk("R2 irq modem", {7'b0, irq_o}, 8'h01);
    rd(6, 8'hA2, "R11 MSR");
    chk("R11 ack", {7'b0, mdm_ack_o}, 8'h01);
    idle();
    chk("R11 ack one cycle", {7'b0, mdm_ack_o}, 8'h00);
    mdm_delta_i = 4'b0000;
    wr(5, 8'hFF);
    rd(5, 8'h60, "R11 LSR write ignored");
    wr(6, 8'hFF);
    rd(6, 8'hA0, "R11 MSR write ignored");
    // loopback
    wr(1, 8'h01);
    wr(4, 8'h1F);
    rd(4, 8'h1F, "R12 MCR");
    chk("R12 mdm_ctrl loop", {3'b0, mdm_ctrl_o}, 8'h1F);
    wr(0, 8'h5A);
    chk("R8 no tx in loopback", {7'b0, tx_stb_o}, 8'h00);
    rd(5, 8'h61, "R8 loopback push");
    rxp(8'h99);
    rd(0, 8'h5A, "R8 loopback byte");
    rd(0, 8'hFF, "R8 rx ignored in loopback");
    idle();
    idle();
    done = 1'b1;
    finish_run();
  end

endmodule